// File: doc/BRIEF.md
# DMA Channel Status and Control Register File

This block is the shared register file of a multi-channel peripheral DMA engine, sized for 16 channels by default. It holds three 32-bit registers. The control register carries a pause (freeze) bit and a one-shot soft-reset request for every channel. The completion register carries per-channel done flags and their interrupt enables. The error register records termination errors and bus errors. The channel engines report events as single-cycle pulses. The block turns those pulses into sticky flags and folds them into a single interrupt line. It also drives the per-channel freeze and reset controls back to the engines.

Software reaches the registers through a simple valid/write/address/data port. Every register has three write views. The base offset replaces the whole register. Base+0x4 sets only the bits written as 1. Base+0x8 clears only the bits written as 1. Software can therefore pause, resume, reset or acknowledge one channel with a one-hot mask, without a read-modify-write. Reads are combinational from the address.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset all three registers read 0, and freeze_o, chan_rst_o and irq_o are 0.
- R2: The register index is addr_i[7:4] (0 = control, 1 = completion, 2 = error) and the write view is addr_i[3:2] (0 = replace, 1 = OR in the 1 bits, 2 = clear the 1 bits). A write takes effect at the next clock edge. A write with addr_i[3:2] = 3, with a register index above 2, with addr_i[1:0] nonzero, or with we_i low changes no register.
- R3: Control bits [15:0] are the freeze bits, and freeze_o[n] follows control bit n. Setting the bit pauses channel n and clearing it resumes the channel.
- R4: Writing 1 to control bit 16+n, through the replace or the OR view, makes chan_rst_o[n] and that bit read 1 for exactly the one cycle after the write. Both then return to 0 with no further write.
- R5: A cmpl_i[n] pulse sets completion bit n one cycle later. Completion bits [31:16] are the per-channel interrupt enables, with channel n at bit 16+n.
- R6: A term_err_i[n] pulse sets error bit n. A bus_err_i[n] pulse sets both error bit n and error bit 16+n.
- R7: When an event pulse and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R8: irq_o is 1 while any completion flag n has enable 16+n set, or while any error bit is 1. A completion flag whose enable is clear does not raise irq_o.
- R9: rdata_o shows the register selected by addr_i whenever addr_i[1:0] = 0 and addr_i[3:2] is 0, 1 or 2. Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access valid |
| we_i | input | 1 | Access is a write |
| addr_i | input | 8 | Byte address: register index and write view |
| wdata_i | input | 32 | Write data or bit mask |
| rdata_o | output | 32 | Read data for addr_i |
| cmpl_i | input | 16 | Per-channel completion pulses |
| term_err_i | input | 16 | Per-channel termination-error pulses |
| bus_err_i | input | 16 | Per-channel bus-error pulses |
| freeze_o | output | 16 | Per-channel pause control |
| chan_rst_o | output | 16 | Per-channel one-cycle soft-reset pulse |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two functions can land on one flag in the same cycle: a hardware event setting it and a software clear through the clear view. The bench provokes this twice. It drives a completion pulse in the same cycle as a clear of that channel's flag, and a bus-error pulse in the same cycle as a full clear of the error register. It then reads the register back in the next cycle and expects the flag set by the event to survive, while every other written bit is gone.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  typedef enum logic [1:0] {
    OP_WR   = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_NONE = 2'd3
  } alias_op_e;

  localparam int REG_CTRL = 0;
  localparam int REG_CMPL = 1;
  localparam int REG_ERR  = 2;
  localparam int NREG     = 3;
  localparam int IDX_W    = $clog2(NREG);
endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
  import dma_regs_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0]    addr_i,
  input  logic             req_i,
  input  logic             we_i,
  output logic [NREG-1:0]  wr_sel_o,
  output alias_op_e        op_o,
  output logic             rd_hit_o,
  output logic [IDX_W-1:0] rd_idx_o
);
  logic [AW-5:0] reg_field;
  logic          hit;

  assign reg_field = addr_i[AW-1:4];
  assign op_o      = alias_op_e'(addr_i[3:2]);
  assign hit       = (addr_i[1:0] == 2'b00) && (op_o != OP_NONE) &&
                     (int'(reg_field) < NREG);
  assign rd_hit_o  = hit;
  assign rd_idx_o  = reg_field[IDX_W-1:0];

  always_comb begin
    wr_sel_o = '0;
    for (int i = 0; i < NREG; i++)
      if (hit && req_i && we_i && (int'(reg_field) == i)) wr_sel_o[i] = 1'b1;
  end
endmodule

// File: rtl/dma_alias_reg.sv
module dma_alias_reg
  import dma_regs_pkg::*;
#(
  parameter int          W       = 32,
  parameter logic [W-1:0] AUTOCLR = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  alias_op_e    op_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] hw_set_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d, q_q;

  always_comb begin
    q_d = q_q & ~AUTOCLR;  // one-shot bits drop after one cycle
    if (wr_en_i) begin
      unique case (op_i)
        OP_WR:   q_d = wdata_i;
        OP_SET:  q_d = q_d | wdata_i;
        OP_CLR:  q_d = q_d & ~wdata_i;
        default: q_d = q_d;
      endcase
    end
    q_d = q_d | hw_set_i;  // events beat software clears
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  p_set_alias_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && op_i == OP_SET) |=> ((q_o & $past(wdata_i)) == $past(wdata_i)));

  p_clr_alias_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && op_i == OP_CLR) |=>
      ((q_o & $past(wdata_i) & ~$past(hw_set_i)) == '0));

  p_hw_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_set_i) |=> ((q_o & $past(hw_set_i)) == $past(hw_set_i)));
endmodule

// File: rtl/dma_irq_merge.sv
module dma_irq_merge #(
  parameter int NCH = 16
) (
  input  logic [2*NCH-1:0] cmpl_q_i,
  input  logic [2*NCH-1:0] err_q_i,
  output logic             irq_o
);
  logic [NCH-1:0] live;

  assign live  = cmpl_q_i[NCH-1:0] & cmpl_q_i[2*NCH-1:NCH];
  assign irq_o = (|live) | (|err_q_i);
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int NCH = 16,
  parameter int AW  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [2*NCH-1:0]  wdata_i,
  output logic [2*NCH-1:0]  rdata_o,
  input  logic [NCH-1:0]    cmpl_i,
  input  logic [NCH-1:0]    term_err_i,
  input  logic [NCH-1:0]    bus_err_i,
  output logic [NCH-1:0]    freeze_o,
  output logic [NCH-1:0]    chan_rst_o,
  output logic              irq_o
);
  localparam int DW = 2 * NCH;

  logic [NREG-1:0]  wr_sel;
  alias_op_e        op;
  logic             rd_hit;
  logic [IDX_W-1:0] rd_idx;
  logic [DW-1:0]    hw_set [NREG];
  logic [DW-1:0]    reg_q  [NREG];

  dma_reg_decode #(.AW(AW)) u_dec (
    .addr_i   (addr_i),
    .req_i    (req_i),
    .we_i     (we_i),
    .wr_sel_o (wr_sel),
    .op_o     (op),
    .rd_hit_o (rd_hit),
    .rd_idx_o (rd_idx)
  );

  assign hw_set[REG_CTRL] = '0;
  assign hw_set[REG_CMPL] = {{NCH{1'b0}}, cmpl_i};
  assign hw_set[REG_ERR]  = {bus_err_i, term_err_i | bus_err_i};

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DW-1:0] ACLR = (g == REG_CTRL) ? {{NCH{1'b1}}, {NCH{1'b0}}} : '0;
    dma_alias_reg #(.W(DW), .AUTOCLR(ACLR)) u_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_sel[g]),
      .op_i     (op),
      .wdata_i  (wdata_i),
      .hw_set_i (hw_set[g]),
      .q_o      (reg_q[g])
    );
  end

  dma_irq_merge #(.NCH(NCH)) u_irq (
    .cmpl_q_i (reg_q[REG_CMPL]),
    .err_q_i  (reg_q[REG_ERR]),
    .irq_o    (irq_o)
  );

  assign freeze_o   = reg_q[REG_CTRL][NCH-1:0];
  assign chan_rst_o = reg_q[REG_CTRL][DW-1:NCH];
  assign rdata_o    = rd_hit ? reg_q[rd_idx] : '0;

  p_rst_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|chan_rst_o) |=> ((chan_rst_o & $past(chan_rst_o)) == '0));

  p_bus_err_both_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bus_err_i) |=> ((reg_q[REG_ERR][NCH-1:0] & $past(bus_err_i)) == $past(bus_err_i)) &&
                     ((reg_q[REG_ERR][DW-1:NCH] & $past(bus_err_i)) == $past(bus_err_i)));

  p_err_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|term_err_i || |bus_err_i) |=> irq_o);
endmodule

// File: tb/sim_dma_chan_regs.sv
module sim_dma_chan_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] cmpl_i = '0, term_err_i = '0, bus_err_i = '0;
  logic [15:0] freeze_o, chan_rst_o;
  logic        irq_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  dma_chan_regs u0 (.*);

  typedef struct {
    int          kind;   // 0 rdata, 1 freeze, 2 chan_rst, 3 irq
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int    n_chk = 0, n_bad = 0;
  bit    done = 0;

  // monitor: samples before the next rising edge
  initial forever begin
    @(negedge clk_i);
    #2;
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = rdata_o;
        1: act = {16'h0, freeze_o};
        2: act = {16'h0, chan_rst_o};
        default: act = {31'h0, irq_o};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic drive(input logic r, input logic w, input logic [7:0] a,
                       input logic [31:0] d, input logic [15:0] c,
                       input logic [15:0] t, input logic [15:0] b);
    @(negedge clk_i);
    req_i = r; we_i = w; addr_i = a; wdata_i = d;
    cmpl_i = c; term_err_i = t; bus_err_i = b;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    drive(1, 1, a, d, 0, 0, 0);
  endtask

  task automatic push(input int k, input logic [31:0] e, input string tag);
    item_t it;
    it.kind = k; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    drive(0, 0, a, 0, 0, 0, 0);
    push(0, e, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk_rd(8'h00, 32'h0, "R1 ctrl");
    push(1, 0, "R1 freeze"); push(2, 0, "R1 chan_rst"); push(3, 0, "R1 irq");
    chk_rd(8'h10, 32'h0, "R1 cmpl");
    chk_rd(8'h20, 32'h0, "R1 err");
    // R3 freeze, R2 views
    wr(8'h00, 32'h5);
    chk_rd(8'h00, 32'h5, "R2 replace"); push(1, 32'h5, "R3 freeze");
    wr(8'h04, 32'h100);
    chk_rd(8'h00, 32'h105, "R2 set view"); push(1, 32'h105, "R3 pause ch8");
    wr(8'h08, 32'h1);
    chk_rd(8'h00, 32'h104, "R2 clr view"); push(1, 32'h104, "R3 resume ch0");
    // R4 one-shot reset
    wr(8'h04, 32'h0004_0000);
    chk_rd(8'h00, 32'h0004_0104, "R4 reset bit reads 1"); push(2, 32'h4, "R4 pulse on");
    chk_rd(8'h00, 32'h104, "R4 reset bit self-clears"); push(2, 0, "R4 pulse off");
    // R2 ignored writes
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h11, 32'hFFFF_FFFF);
    drive(1, 0, 8'h10, 32'hFFFF_FFFF, 0, 0, 0);
    chk_rd(8'h00, 32'h104, "R2 ignored ctrl"); push(1, 32'h104, "R2 freeze untouched");
    push(2, 0, "R2 no reset pulse");
    chk_rd(8'h10, 32'h0, "R2 ignored cmpl");
    chk_rd(8'h0C, 32'h0, "R9 view 3 reads 0");
    chk_rd(8'h40, 32'h0, "R9 unmapped reads 0");
    // R5 completion, R8 masking
    drive(0, 0, 8'h00, 0, 16'h0008, 0, 0);
    chk_rd(8'h10, 32'h8, "R5 flag ch3"); push(3, 0, "R8 masked flag");
    wr(8'h14, 32'h0008_0000);
    chk_rd(8'h10, 32'h0008_0008, "R5 enable ch3"); push(3, 1, "R8 enabled flag");
    chk_rd(8'h14, 32'h0008_0008, "R9 set view reads reg");
    wr(8'h18, 32'h8);
    chk_rd(8'h10, 32'h0008_0000, "R5 ack ch3"); push(3, 0, "R8 irq drops");
    // R7 event vs clear
    drive(1, 1, 8'h18, 32'h20, 16'h0020, 0, 0);
    chk_rd(8'h10, 32'h0008_0020, "R7 cmpl wins");
    wr(8'h18, 32'h20);
    chk_rd(8'h10, 32'h0008_0000, "R7 later clear");
    // R6 errors
    drive(0, 0, 8'h00, 0, 0, 16'h0002, 0);
    chk_rd(8'h20, 32'h2, "R6 term err"); push(3, 1, "R8 err irq");
    drive(0, 0, 8'h00, 0, 0, 0, 16'h0080);
    chk_rd(8'h20, 32'h0080_0082, "R6 bus err both halves");
    drive(1, 1, 8'h28, 32'hFFFF_FFFF, 0, 0, 16'h0001);
    chk_rd(8'h20, 32'h0001_0001, "R7 bus err wins");
    wr(8'h28, 32'hFFFF_FFFF);
    chk_rd(8'h20, 32'h0, "R6 err cleared"); push(3, 0, "R8 irq idle");
    // R2 replace on completion, R8 mixed
    wr(8'h10, 32'h1234_5678);
    chk_rd(8'h10, 32'h1234_5678, "R2 replace cmpl"); push(3, 1, "R8 mixed");
    wr(8'h10, 32'h0);
    chk_rd(8'h10, 32'h0, "R2 replace zero"); push(3, 0, "R8 quiet");
    drive(0, 0, 8'h00, 0, 0, 0, 0);
    @(negedge clk_i);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule